// File: doc/BRIEF.md
# Context-Tagged Address Translator with Two-Level Walk

This block turns 32-bit virtual byte addresses into physical byte addresses for one requester. Pages are 4 KB, so the upper 20 bits of an address select a page and the lower 12 bits pass through unchanged. Recent translations live in a small, fully associative translation cache. Each entry is tagged with the address-space number that was active when it was filled, so several processes can keep entries resident at once. Moving from one process to another only takes a write of the context number and the directory page number. The cache does not need to be emptied.

When the cache has no matching entry, a hardware walker reads a two-tier page map through a word-addressed read port. The directory tier is indexed by virtual address bits 31:22. The table tier is indexed by bits 21:12. Each tier occupies one physical page of 1024 words. A successful walk installs the result in a slot picked by a rotating pointer and returns the translation. A walk that meets a missing entry at either tier returns a page-fault response instead. A flush strobe discards every cached translation.

Top module: `ctx_mmu`

## Requirements
- R1: After reset, req_ready_o is 1, resp_valid_o and mem_req_o are 0, and the cache holds no entries, so the first translation always walks.
- R2: A translated physical address is the 20-bit physical page number in bits 31:12 and the request's own bits 11:0 in bits 11:0.
- R3: A request that hits is answered in the cycle right after the edge that accepts it (resp_valid_o high, fault low), and it issues no memory read.
- R4: A miss issues two reads. The first is at word address {page_directory, va[31:22]}. The second is at word address {directory_entry[31:12], va[21:12]}. The response comes in the cycle after the second read's data, five cycles after acceptance when each read answers in one cycle. A repeat of the same page then hits.
- R5: A page-map word marks the entry present with bit 0 and holds the page number in bits 31:12. Bits 11:1 are ignored.
- R6: A directory word with bit 0 clear gives resp_fault_o after exactly one read. Nothing is installed, so a repeat walks again.
- R7: A table word with bit 0 clear gives resp_fault_o after both reads. Nothing is installed.
- R8: An entry matches only when its context tag equals the current context number. Changing the context does not remove entries, so returning to an earlier context hits on that context's entries.
- R9: The walk uses the page-directory and context values that were current at acceptance. A register write during a walk does not affect that walk.
- R10: Refills go to slots in rotating order. After NUM_ENTRIES consecutive refills, the next refill evicts the translation that was installed first among them.
- R11: A flush_i pulse invalidates every entry, so every following lookup misses until refilled.
- R12: req_ready_o is 0 from the edge that accepts a miss until the edge that produces its response. No request is accepted while it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request |
| req_vaddr_i | input | 32 | Virtual byte address |
| req_ready_o | output | 1 | Request accepted on this edge when high |
| resp_valid_o | output | 1 | One-cycle response strobe |
| resp_fault_o | output | 1 | Response is a page fault |
| resp_paddr_o | output | 32 | Physical byte address (zero on fault) |
| ctx_wr_i | input | 1 | Load context number |
| ctx_id_i | input | CTX_W | New context number |
| pdir_wr_i | input | 1 | Load page-directory page number |
| pdir_ppn_i | input | 20 | Physical page holding the directory |
| flush_i | input | 1 | Invalidate all cached translations |
| mem_req_o | output | 1 | Read request, held until mem_rvalid_i |
| mem_addr_o | output | 30 | Word address of the read |
| mem_rdata_i | input | 32 | Read data |
| mem_rvalid_i | input | 1 | Read data valid, ends the request |

## Verification
The bench counts the latency and the memory reads of every translation. A design that walks on a hit, or that fails to install after a walk, shows up as a five-cycle answer where one cycle was expected. Faults are placed at both tiers. A directory fault that still issues a second read, or a fault that installs a junk entry, changes the read count of the repeated access. The bench visits two contexts that map the same virtual page to different frames, and it writes the directory register while a walk is in progress. An untagged lookup returns the wrong frame. An unlatched directory pointer shows up in the logged read address. Rotating replacement is checked by touching five pages in four slots and confirming that only the first-installed page is evicted.

// File: rtl/ctx_mmu_pkg.sv
package ctx_mmu_pkg;
  localparam int unsigned VA_W   = 32;
  localparam int unsigned OFS_W  = 12;
  localparam int unsigned VPN_W  = VA_W - OFS_W;
  localparam int unsigned PPN_W  = 20;
  localparam int unsigned IDX_W  = VPN_W / 2;
  localparam int unsigned WADR_W = PPN_W + IDX_W;
  localparam int unsigned PTE_W  = 32;
  localparam int unsigned PRESENT_BIT = 0;

  typedef enum logic [1:0] {
    WK_IDLE,
    WK_DIR,
    WK_TBL
  } walk_state_e;

  function automatic logic pte_present(input logic [PTE_W-1:0] w);
    return w[PRESENT_BIT];
  endfunction

  function automatic logic [PPN_W-1:0] pte_ppn(input logic [PTE_W-1:0] w);
    return w[PTE_W-1 -: PPN_W];
  endfunction
endpackage

// File: rtl/ctx_mmu_ctxregs.sv
module ctx_mmu_ctxregs
  import ctx_mmu_pkg::*;
#(
  parameter int unsigned CTX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctx_wr_i,
  input  logic [CTX_W-1:0] ctx_i,
  input  logic             pdir_wr_i,
  input  logic [PPN_W-1:0] pdir_i,
  output logic [CTX_W-1:0] ctx_o,
  output logic [PPN_W-1:0] pdir_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctx_o  <= '0;
      pdir_o <= '0;
    end else begin
      if (ctx_wr_i)  ctx_o  <= ctx_i;
      if (pdir_wr_i) pdir_o <= pdir_i;
    end
  end
endmodule

// File: rtl/ctx_mmu_tlb.sv
module ctx_mmu_tlb
  import ctx_mmu_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 4,
  parameter int unsigned CTX_W       = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [CTX_W-1:0]       lk_ctx_i,
  input  logic [VPN_W-1:0]       lk_vpn_i,
  output logic                   lk_hit_o,
  output logic [PPN_W-1:0]       lk_ppn_o,
  output logic [NUM_ENTRIES-1:0] lk_match_o,
  input  logic                   fill_i,
  input  logic [CTX_W-1:0]       fill_ctx_i,
  input  logic [VPN_W-1:0]       fill_vpn_i,
  input  logic [PPN_W-1:0]       fill_ppn_i,
  input  logic                   flush_i
);
  localparam int unsigned PTR_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(NUM_ENTRIES - 1);

  logic [NUM_ENTRIES-1:0] valid_q;
  logic [CTX_W-1:0]       ctx_q [NUM_ENTRIES];
  logic [VPN_W-1:0]       vpn_q [NUM_ENTRIES];
  logic [PPN_W-1:0]       ppn_q [NUM_ENTRIES];
  logic [PTR_W-1:0]       rr_q;
  logic                   do_fill;

  assign do_fill = fill_i && !flush_i;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
    assign lk_match_o[g] = valid_q[g] && (ctx_q[g] == lk_ctx_i) && (vpn_q[g] == lk_vpn_i);
  end

  assign lk_hit_o = |lk_match_o;

  always_comb begin
    lk_ppn_o = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (lk_match_o[i]) lk_ppn_o = lk_ppn_o | ppn_q[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        ctx_q[i] <= '0;
        vpn_q[i] <= '0;
        ppn_q[i] <= '0;
      end
    end else if (flush_i) begin
      valid_q <= '0;
    end else if (do_fill) begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        if (rr_q == PTR_W'(i)) begin
          valid_q[i] <= 1'b1;
          ctx_q[i]   <= fill_ctx_i;
          vpn_q[i]   <= fill_vpn_i;
          ppn_q[i]   <= fill_ppn_i;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rr_q <= '0;
    else if (do_fill) rr_q <= (rr_q == PTR_LAST) ? '0 : rr_q + 1'b1;
  end
endmodule

// File: rtl/ctx_mmu_walker.sv
module ctx_mmu_walker
  import ctx_mmu_pkg::*;
#(
  parameter int unsigned CTX_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [VPN_W-1:0]  vpn_i,
  input  logic [CTX_W-1:0]  ctx_i,
  input  logic [PPN_W-1:0]  pdir_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fault_o,
  output logic [PPN_W-1:0]  ppn_o,
  output logic [VPN_W-1:0]  vpn_o,
  output logic [CTX_W-1:0]  ctx_o,
  output logic              mem_req_o,
  output logic [WADR_W-1:0] mem_addr_o,
  input  logic [PTE_W-1:0]  mem_rdata_i,
  input  logic              mem_rvalid_i
);
  walk_state_e      state_q;
  logic [VPN_W-1:0] vpn_q;
  logic [CTX_W-1:0] ctx_q;
  logic [PPN_W-1:0] pdir_q;
  logic [PPN_W-1:0] tbl_q;
  logic             unused_flags;

  assign unused_flags = ^mem_rdata_i[OFS_W-1:1];

  assign busy_o    = (state_q != WK_IDLE);
  assign mem_req_o = busy_o;
  assign vpn_o     = vpn_q;
  assign ctx_o     = ctx_q;
  assign ppn_o     = pte_ppn(mem_rdata_i);

  always_comb begin
    mem_addr_o = '0;
    done_o     = 1'b0;
    fault_o    = 1'b0;
    unique case (state_q)
      WK_DIR: begin
        mem_addr_o = {pdir_q, vpn_q[VPN_W-1 -: IDX_W]};
        if (mem_rvalid_i && !pte_present(mem_rdata_i)) begin
          done_o  = 1'b1;
          fault_o = 1'b1;
        end
      end
      WK_TBL: begin
        mem_addr_o = {tbl_q, vpn_q[IDX_W-1:0]};
        if (mem_rvalid_i) begin
          done_o  = 1'b1;
          fault_o = !pte_present(mem_rdata_i);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WK_IDLE;
      vpn_q   <= '0;
      ctx_q   <= '0;
      pdir_q  <= '0;
      tbl_q   <= '0;
    end else begin
      unique case (state_q)
        WK_IDLE: if (start_i) begin
          vpn_q   <= vpn_i;
          ctx_q   <= ctx_i;
          pdir_q  <= pdir_i;
          state_q <= WK_DIR;
        end
        WK_DIR: if (mem_rvalid_i) begin
          if (pte_present(mem_rdata_i)) begin
            tbl_q   <= pte_ppn(mem_rdata_i);
            state_q <= WK_TBL;
          end else begin
            state_q <= WK_IDLE;
          end
        end
        WK_TBL: if (mem_rvalid_i) state_q <= WK_IDLE;
        default: state_q <= WK_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ctx_mmu.sv
module ctx_mmu
  import ctx_mmu_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 4,
  parameter int unsigned CTX_W       = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [VA_W-1:0]   req_vaddr_i,
  output logic              req_ready_o,
  output logic              resp_valid_o,
  output logic              resp_fault_o,
  output logic [VA_W-1:0]   resp_paddr_o,
  input  logic              ctx_wr_i,
  input  logic [CTX_W-1:0]  ctx_id_i,
  input  logic              pdir_wr_i,
  input  logic [PPN_W-1:0]  pdir_ppn_i,
  input  logic              flush_i,
  output logic              mem_req_o,
  output logic [WADR_W-1:0] mem_addr_o,
  input  logic [PTE_W-1:0]  mem_rdata_i,
  input  logic              mem_rvalid_i
);
  logic [CTX_W-1:0]       cur_ctx;
  logic [PPN_W-1:0]       cur_pdir;
  logic                   lk_hit;
  logic [PPN_W-1:0]       lk_ppn;
  logic [NUM_ENTRIES-1:0] lk_match;
  logic                   accept, hit_acc, miss_acc;
  logic                   wk_busy, wk_done, wk_fault;
  logic [PPN_W-1:0]       wk_ppn;
  logic [VPN_W-1:0]       wk_vpn;
  logic [CTX_W-1:0]       wk_ctx;
  logic [OFS_W-1:0]       ofs_q;
  logic                   rsp_v_q, rsp_f_q;
  logic [VA_W-1:0]        rsp_pa_q;

  assign req_ready_o = !wk_busy;
  assign accept      = req_valid_i && req_ready_o;
  assign hit_acc     = accept && lk_hit;
  assign miss_acc    = accept && !lk_hit;

  ctx_mmu_ctxregs #(.CTX_W(CTX_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ctx_wr_i (ctx_wr_i),
    .ctx_i    (ctx_id_i),
    .pdir_wr_i(pdir_wr_i),
    .pdir_i   (pdir_ppn_i),
    .ctx_o    (cur_ctx),
    .pdir_o   (cur_pdir)
  );

  ctx_mmu_tlb #(.NUM_ENTRIES(NUM_ENTRIES), .CTX_W(CTX_W)) u_tlb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lk_ctx_i  (cur_ctx),
    .lk_vpn_i  (req_vaddr_i[VA_W-1:OFS_W]),
    .lk_hit_o  (lk_hit),
    .lk_ppn_o  (lk_ppn),
    .lk_match_o(lk_match),
    .fill_i    (wk_done && !wk_fault),
    .fill_ctx_i(wk_ctx),
    .fill_vpn_i(wk_vpn),
    .fill_ppn_i(wk_ppn),
    .flush_i   (flush_i)
  );

  ctx_mmu_walker #(.CTX_W(CTX_W)) u_walk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (miss_acc),
    .vpn_i       (req_vaddr_i[VA_W-1:OFS_W]),
    .ctx_i       (cur_ctx),
    .pdir_i      (cur_pdir),
    .busy_o      (wk_busy),
    .done_o      (wk_done),
    .fault_o     (wk_fault),
    .ppn_o       (wk_ppn),
    .vpn_o       (wk_vpn),
    .ctx_o       (wk_ctx),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_rdata_i (mem_rdata_i),
    .mem_rvalid_i(mem_rvalid_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ofs_q    <= '0;
      rsp_v_q  <= 1'b0;
      rsp_f_q  <= 1'b0;
      rsp_pa_q <= '0;
    end else begin
      if (miss_acc) ofs_q <= req_vaddr_i[OFS_W-1:0];
      rsp_v_q <= hit_acc || wk_done;
      rsp_f_q <= wk_done && wk_fault;
      if (hit_acc)                   rsp_pa_q <= {lk_ppn, req_vaddr_i[OFS_W-1:0]};
      else if (wk_done && !wk_fault) rsp_pa_q <= {wk_ppn, ofs_q};
      else if (wk_done)              rsp_pa_q <= '0;
    end
  end

  assign resp_valid_o = rsp_v_q;
  assign resp_fault_o = rsp_f_q;
  assign resp_paddr_o = rsp_pa_q;
endmodule

// File: rtl/ctx_mmu_chk.sv
module ctx_mmu_chk
  import ctx_mmu_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 4
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   req_valid_i,
  input logic [VA_W-1:0]        req_vaddr_i,
  input logic                   req_ready_o,
  input logic                   resp_valid_o,
  input logic                   resp_fault_o,
  input logic [VA_W-1:0]        resp_paddr_o,
  input logic                   mem_req_o,
  input logic [WADR_W-1:0]      mem_addr_o,
  input logic                   mem_rvalid_i,
  input logic                   lk_hit,
  input logic [NUM_ENTRIES-1:0] lk_match
);
  logic [OFS_W-1:0] ofs_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         ofs_seen <= '0;
    else if (req_valid_i && req_ready_o) ofs_seen <= req_vaddr_i[OFS_W-1:0];
  end

  AST_FAULT_IS_RESPONSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_fault_o |-> resp_valid_o);  // R6
  AST_OFFSET_PASSTHRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && !resp_fault_o) |-> (resp_paddr_o[OFS_W-1:0] == ofs_seen));  // R2
  AST_SINGLE_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_match));  // R8
  AST_NO_READ_WHILE_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o);  // R12
  AST_READ_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));  // R4
  AST_HIT_NEXT_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && lk_hit) |=> (resp_valid_o && !resp_fault_o && !mem_req_o));  // R3
endmodule

bind ctx_mmu ctx_mmu_chk #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_vaddr_i (req_vaddr_i),
  .req_ready_o (req_ready_o),
  .resp_valid_o(resp_valid_o),
  .resp_fault_o(resp_fault_o),
  .resp_paddr_o(resp_paddr_o),
  .mem_req_o   (mem_req_o),
  .mem_addr_o  (mem_addr_o),
  .mem_rvalid_i(mem_rvalid_i),
  .lk_hit      (lk_hit),
  .lk_match    (lk_match)
);

// File: tb/ctx_mmu_test.sv
`timescale 1ns/1ps
module ctx_mmu_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_vaddr_i = '0;
  logic        req_ready_o, resp_valid_o, resp_fault_o;
  logic [31:0] resp_paddr_o;
  logic        ctx_wr_i = 1'b0;
  logic [3:0]  ctx_id_i = '0;
  logic        pdir_wr_i = 1'b0;
  logic [19:0] pdir_ppn_i = '0;
  logic        flush_i = 1'b0;
  logic        mem_req_o;
  logic [29:0] mem_addr_o;
  logic [31:0] mem_rdata_i = '0;
  logic        mem_rvalid_i = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  int rd_cnt = 0;
  logic [29:0] rd_log [2];
  logic [31:0] pmem [logic [29:0]];

  always #2.5 clk_i = ~clk_i;

  ctx_mmu #(.NUM_ENTRIES(4), .CTX_W(4)) uut (
    .clk_i, .rst_ni, .req_valid_i, .req_vaddr_i, .req_ready_o,
    .resp_valid_o, .resp_fault_o, .resp_paddr_o,
    .ctx_wr_i, .ctx_id_i, .pdir_wr_i, .pdir_ppn_i, .flush_i,
    .mem_req_o, .mem_addr_o, .mem_rdata_i, .mem_rvalid_i
  );

  // one-cycle memory model; absent words read as not-present with junk flag bits
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      mem_rvalid_i <= 1'b0;
    end else begin
      if (mem_req_o && mem_rvalid_i) begin
        if (rd_cnt < 2) rd_log[rd_cnt] = mem_addr_o;
        rd_cnt = rd_cnt + 1;
      end
      mem_rvalid_i <= mem_req_o && !mem_rvalid_i;
      if (mem_req_o && !mem_rvalid_i)
        mem_rdata_i <= pmem.exists(mem_addr_o) ? pmem[mem_addr_o] : 32'h0000_0FFE;
    end
  end

  function automatic logic [31:0] pte(input logic [19:0] ppn, input logic [11:0] flags);
    return {ppn, flags};
  endfunction

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic set_ctx(input logic [3:0] c, input logic [19:0] d);
    @(negedge clk_i);
    ctx_wr_i = 1'b1; ctx_id_i = c; pdir_wr_i = 1'b1; pdir_ppn_i = d;
    @(negedge clk_i);
    ctx_wr_i = 1'b0; pdir_wr_i = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk_i); flush_i = 1'b1;
    @(negedge clk_i); flush_i = 1'b0;
  endtask

  task automatic xlate(input logic [31:0] va, input bit poke, output logic [31:0] pa,
                       output logic flt, output int lat, output logic rdy_mid);
    @(negedge clk_i);
    while (!req_ready_o) @(negedge clk_i);
    req_valid_i = 1'b1; req_vaddr_i = va; rd_cnt = 0;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    rdy_mid = req_ready_o;
    if (poke) begin pdir_wr_i = 1'b1; pdir_ppn_i = 20'hFFFFF; end
    lat = 1;
    while (!resp_valid_o && lat < 40) begin
      @(negedge clk_i);
      pdir_wr_i = 1'b0;
      lat++;
    end
    pdir_wr_i = 1'b0;
    pa = resp_paddr_o; flt = resp_fault_o;
  endtask

  logic [31:0] pa;
  logic        flt, rm;
  int          lat;

  task automatic t_reset();
    chk("R1", "ready after reset", 32'(req_ready_o), 1);
    chk("R1", "resp_valid after reset", 32'(resp_valid_o), 0);
    chk("R1", "mem_req after reset", 32'(mem_req_o), 0);
  endtask

  task automatic t_walk_hit();
    set_ctx(4'd1, 20'h00010);
    xlate(32'h0040_3ABC, 0, pa, flt, lat, rm);
    chk("R1", "first access walks", 32'(lat), 5);
    chk("R2", "walk paddr", pa, 32'hABCD_EABC);
    chk("R5", "flag bits ignored, no fault", 32'(flt), 0);
    chk("R4", "walk read count", 32'(rd_cnt), 2);
    chk("R4", "directory read addr", 32'(rd_log[0]), 32'({20'h00010, 10'h001}));
    chk("R4", "table read addr", 32'(rd_log[1]), 32'({20'h00020, 10'h003}));
    chk("R12", "ready low during walk", 32'(rm), 0);
    xlate(32'h0040_3ABC, 0, pa, flt, lat, rm);
    chk("R3", "hit latency", 32'(lat), 1);
    chk("R3", "hit reads", 32'(rd_cnt), 0);
    chk("R3", "hit paddr", pa, 32'hABCD_EABC);
    xlate(32'h0040_3123, 0, pa, flt, lat, rm);
    chk("R2", "other offset same page", pa, 32'hABCD_E123);
    chk("R3", "other offset hit latency", 32'(lat), 1);
  endtask

  task automatic t_dir_fault();
    for (int k = 0; k < 2; k++) begin
      xlate(32'h8000_0010, 0, pa, flt, lat, rm);
      chk("R6", "directory fault flag", 32'(flt), 1);
      chk("R6", "directory fault latency", 32'(lat), 3);
      chk("R6", "directory fault single read", 32'(rd_cnt), 1);
      chk("R6", "fault paddr zero", pa, 0);
    end
  endtask

  task automatic t_tbl_fault();
    for (int k = 0; k < 2; k++) begin
      xlate(32'h0040_4000, 0, pa, flt, lat, rm);
      chk("R7", "table fault flag", 32'(flt), 1);
      chk("R7", "table fault latency", 32'(lat), 5);
      chk("R7", "table fault reads", 32'(rd_cnt), 2);
    end
  endtask

  task automatic t_context();
    set_ctx(4'd2, 20'h00030);
    xlate(32'h0040_3ABC, 0, pa, flt, lat, rm);
    chk("R8", "other context misses", 32'(lat), 5);
    chk("R9", "other context frame", pa, 32'h1234_5ABC);
    chk("R9", "walk starts at new directory", 32'(rd_log[0]), 32'({20'h00030, 10'h001}));
    set_ctx(4'd1, 20'h00010);
    xlate(32'h0040_3ABC, 0, pa, flt, lat, rm);
    chk("R8", "back to context 1 hits", 32'(lat), 1);
    chk("R8", "context 1 frame", pa, 32'hABCD_EABC);
    set_ctx(4'd2, 20'h00030);
    xlate(32'h0040_3ABC, 0, pa, flt, lat, rm);
    chk("R8", "context 2 retained", 32'(lat), 1);
    chk("R8", "context 2 frame", pa, 32'h1234_5ABC);
  endtask

  task automatic t_latch();
    xlate(32'h0040_5000, 1, pa, flt, lat, rm);
    chk("R9", "walk ignores mid-walk dir write", pa, 32'h0BEE_F000);
    chk("R9", "directory addr from accepted value", 32'(rd_log[0]), 32'({20'h00030, 10'h001}));
    chk("R9", "no fault", 32'(flt), 0);
    set_ctx(4'd2, 20'h00030);
  endtask

  task automatic t_flush();
    set_ctx(4'd1, 20'h00010);
    do_flush();
    xlate(32'h0040_3ABC, 0, pa, flt, lat, rm);
    chk("R11", "walk after flush", 32'(lat), 5);
    chk("R11", "paddr after flush", pa, 32'hABCD_EABC);
  endtask

  task automatic t_replace();
    for (int i = 0; i < 5; i++) begin
      xlate(32'h0041_0000 + (32'(i) << 12), 0, pa, flt, lat, rm);
      chk("R10", $sformatf("fill page %0d latency", i), 32'(lat), 5);
    end
    for (int i = 1; i < 5; i++) begin
      xlate(32'h0041_0000 + (32'(i) << 12) + 32'h44, 0, pa, flt, lat, rm);
      chk("R10", $sformatf("page %0d kept", i), 32'(lat), 1);
      chk("R10", $sformatf("page %0d frame", i), pa, {20'h50000 + 20'(i), 12'h044});
    end
    xlate(32'h0041_0000, 0, pa, flt, lat, rm);
    chk("R10", "oldest page evicted", 32'(lat), 5);
  endtask

  initial begin
    pmem[{20'h00010, 10'h001}] = pte(20'h00020, 12'hFFF);
    pmem[{20'h00020, 10'h003}] = pte(20'hABCDE, 12'hFF1);
    for (int i = 0; i < 5; i++)
      pmem[{20'h00020, 10'h010 + 10'(i)}] = pte(20'h50000 + 20'(i), 12'h001);
    pmem[{20'h00030, 10'h001}] = pte(20'h00040, 12'h001);
    pmem[{20'h00040, 10'h003}] = pte(20'h12345, 12'h001);
    pmem[{20'h00040, 10'h005}] = pte(20'h0BEEF, 12'h001);
    pmem[{20'hFFFFF, 10'h001}] = pte(20'h00077, 12'h001);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_walk_hit();
    t_dir_fault();
    t_tbl_fault();
    t_context();
    t_latch();
    t_flush();
    t_replace();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule